// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Burst Line Refill

This block is a blocking, direct-mapped read cache that sits between an in-order processor and a 32-bit memory bus. The processor issues word reads over a valid/ready request channel; a read whose line is resident returns its word one cycle after it is accepted. A read that misses starts one bus transaction that brings in the whole line, one 32-bit word per beat. The cache holds the processor off until the final word of that line has been written.

The request channel applies back-pressure: a request transfers only in a cycle where both `req_valid` and `req_ready` are high, and `req_ready` stays low for the whole refill. The response channel has no back-pressure. The in-order processor must take `rsp_data` in the one cycle that `rsp_valid` is high. On the bus side, the cache issues a single address cycle. The memory always accepts it and answers on a fixed timeline: four idle cycles, then one data beat per cycle, flagged by `mem_beat_valid`. A miss therefore costs 1 + 4 + B cycles on top of the one-cycle hit, where B is the line length in words (`LINE_WORDS`: 1, 4, 8 or 16).

Top module: `burst_fill_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_cmd_valid` is 0, and every line is invalid, so the first read of any address misses.
- R2: An accepted read whose line is resident raises `rsp_valid` in the next cycle with the stored word, and issues no bus command.
- R3: An accepted read that misses raises `mem_cmd_valid` for exactly one cycle, the cycle after acceptance. `mem_cmd_addr` is the line-aligned byte address, with its low 2 + log2(B) bits zero.
- R4: From the cycle after a missing read is accepted until its response cycle, `req_ready` is 0, so no request can be accepted. `req_ready` is 1 again in the response cycle.
- R5: Beat i of a burst (counting from 0) is stored as word offset i of the line, in ascending address order. The response carries the word at the requested offset, whatever that offset is.
- R6: With the memory timeline above, the response to a miss comes in the cycle after the last beat, that is 6 + B cycles after the request cycle.
- R7: Tag and valid bit are written only with the final beat. Afterwards every word of the refilled line hits.
- R8: A read with the same index but a different tag refills the line. The address that was displaced misses on its next read.
- R9: Data beats that arrive while no refill is in progress are ignored. They produce no response and leave the stored data unchanged.
- R10: Address bits [1:0] (the byte within a word) have no effect on hit detection or on the word returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor read request valid |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | Read data valid (one cycle, no back-pressure) |
| rsp_data | output | 32 | Read data word |
| mem_cmd_valid | output | 1 | Bus address cycle |
| mem_cmd_addr | output | 32 | Line-aligned byte address of the burst |
| mem_beat_valid | input | 1 | Bus data beat present this cycle |
| mem_beat_data | input | 32 | Bus data word |

## Verification
The request is presented in cycle 0. A hit response is due in cycle 1. For a miss, the bus command is due in cycle 1, the beats arrive in cycles 6 to 5 + B, and the response is due in cycle 6 + B. The bench drives inputs and samples outputs on the falling clock edge. Each read task counts falling edges from the request cycle, notes the first cycle in which `rsp_valid` is high, and compares that count with 1 or 6 + B. In the same walk it checks that `req_ready` is low in cycle 2 of a miss and high again in the response cycle. The bench's memory model keeps the four-idle-cycle timeline, and word data is a function of the address, so a beat stored out of order shows up as a wrong word on a later hit.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE  = 2'd0,
    FILL_CMD   = 2'd1,
    FILL_BEATS = 2'd2
  } fill_state_e;

  // Number of address bits needed to pick one of n items (0 when n == 1).
  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction

  // Width of a signal that holds a selector; never zero.
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bfc_tag_store.sv
module bfc_tag_store #(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 24,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [NUM_LINES-1:0] line_valid;
  logic [TAG_W-1:0]     line_tag [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_valid[g] <= 1'b0;
      end else if (sel) begin
        line_valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        line_tag[g] <= wr_tag;
      end
    end
  end

  assign lk_hit = line_valid[lk_idx] && (line_tag[lk_idx] == lk_tag);

endmodule

// File: rtl/bfc_data_store.sv
module bfc_data_store #(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter int OFF_W      = 2
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] words [NUM_LINES][LINE_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      words[wr_idx][wr_off] <= wr_data;
    end
  end

  assign rd_data = words[rd_idx][rd_off];

endmodule

// File: rtl/bfc_refill_ctrl.sv
module bfc_refill_ctrl
  import bfc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int OFF_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              beat_valid,
  output logic              beat_we,
  output logic [OFF_W-1:0]  beat_off,
  output logic              last_beat
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

  fill_state_e      state_q, state_d;
  logic [OFF_W-1:0] cnt_q;

  assign busy      = (state_q != FILL_IDLE);
  assign cmd_valid = (state_q == FILL_CMD);
  assign beat_we   = (state_q == FILL_BEATS) && beat_valid;
  assign beat_off  = cnt_q;
  assign last_beat = beat_we && (cnt_q == LAST_OFF);

  always_comb begin
    state_d = state_q;
    case (state_q)
      FILL_IDLE:  if (start) state_d = FILL_CMD;
      FILL_CMD:   state_d = FILL_BEATS;
      FILL_BEATS: if (last_beat) state_d = FILL_IDLE;
      default:    state_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FILL_IDLE;
      cnt_q    <= '0;
      cmd_addr <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == FILL_IDLE && start) begin
        cmd_addr <= start_addr;
        cnt_q    <= '0;
      end else if (beat_we) begin
        cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_fill_cache.sv
module burst_fill_cache
  import bfc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_cmd_valid,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data
);

  localparam int OFF_BITS = sel_bits(LINE_WORDS);
  localparam int OFF_W    = sel_width(LINE_WORDS);
  localparam int IDX_W    = sel_bits(NUM_LINES);
  localparam int WA_W     = ADDR_W - 2;
  localparam int TAG_W    = WA_W - OFF_BITS - IDX_W;
  localparam int LOW_W    = 2 + OFF_BITS;

  // Address split: tag | index | word offset | byte
  logic [WA_W-1:0]  word_addr;
  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [ADDR_W-1:0] line_addr;
  logic unused_byte_bits;

  assign word_addr        = req_addr[ADDR_W-1:2];
  assign unused_byte_bits = ^req_addr[1:0];
  assign req_idx          = word_addr[OFF_BITS +: IDX_W];
  assign req_tag          = word_addr[WA_W-1 -: TAG_W];
  assign line_addr        = {req_addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};

  if (OFF_BITS == 0) begin : g_single_word
    assign req_off = '0;
  end else begin : g_multi_word
    assign req_off = word_addr[OFF_BITS-1:0];
  end

  // Pending-miss context
  logic [IDX_W-1:0]  pend_idx;
  logic [TAG_W-1:0]  pend_tag;
  logic [OFF_W-1:0]  pend_off;
  logic [DATA_W-1:0] crit_q;

  logic              lk_hit;
  logic              busy;
  logic              accept;
  logic              start;
  logic              beat_we;
  logic [OFF_W-1:0]  beat_off;
  logic              last_beat;
  logic [DATA_W-1:0] rd_data;
  logic              beat_is_crit;

  assign req_ready    = !busy;
  assign accept       = req_valid && req_ready;
  assign start        = accept && !lk_hit;
  assign beat_is_crit = (beat_off == pend_off);

  bfc_tag_store #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W),
    .IDX_W     (IDX_W)
  ) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_idx (req_idx),
    .lk_tag (req_tag),
    .lk_hit (lk_hit),
    .wr_en  (last_beat),
    .wr_idx (pend_idx),
    .wr_tag (pend_tag)
  );

  bfc_data_store #(
    .NUM_LINES  (NUM_LINES),
    .LINE_WORDS (LINE_WORDS),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .OFF_W      (OFF_W)
  ) u_data (
    .clk     (clk),
    .rd_idx  (req_idx),
    .rd_off  (req_off),
    .rd_data (rd_data),
    .wr_en   (beat_we),
    .wr_idx  (pend_idx),
    .wr_off  (beat_off),
    .wr_data (mem_beat_data)
  );

  bfc_refill_ctrl #(
    .ADDR_W     (ADDR_W),
    .LINE_WORDS (LINE_WORDS),
    .OFF_W      (OFF_W)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (line_addr),
    .busy       (busy),
    .cmd_valid  (mem_cmd_valid),
    .cmd_addr   (mem_cmd_addr),
    .beat_valid (mem_beat_valid),
    .beat_we    (beat_we),
    .beat_off   (beat_off),
    .last_beat  (last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idx  <= '0;
      pend_tag  <= '0;
      pend_off  <= '0;
      crit_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (start) begin
        pend_idx <= req_idx;
        pend_tag <= req_tag;
        pend_off <= req_off;
      end
      if (beat_we && beat_is_crit) begin
        crit_q <= mem_beat_data;
      end
      rsp_valid <= (accept && lk_hit) || last_beat;
      if (accept && lk_hit) begin
        rsp_data <= rd_data;
      end else if (last_beat) begin
        rsp_data <= beat_is_crit ? mem_beat_data : crit_q;
      end
    end
  end

endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              mem_cmd_valid,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic              mem_beat_valid
);

  localparam int LOW_W = 2 + ((LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 0);

  logic unused_chk;
  assign unused_chk = ^req_addr;

  // R3: a bus command only follows an accepted request
  p_cmd_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> $past(req_valid && req_ready));

  // R3: the address cycle lasts exactly one cycle
  p_cmd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |=> !mem_cmd_valid);

  // R3: burst address is line aligned
  p_cmd_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (mem_cmd_addr[LOW_W-1:0] == '0));

  // R4: no request can be accepted while the address cycle is out
  p_stall_during_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> !req_ready);

  // R6: a response follows either an acceptance (hit) or a data beat (last of a burst)
  p_rsp_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_beat_valid)));

  // R2: a hit response never shares a cycle with a bus command
  p_hit_no_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_cmd_valid);

endmodule

bind burst_fill_cache bfc_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_WORDS (LINE_WORDS)
) u_bfc_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_addr       (req_addr),
  .rsp_valid      (rsp_valid),
  .mem_cmd_valid  (mem_cmd_valid),
  .mem_cmd_addr   (mem_cmd_addr),
  .mem_beat_valid (mem_beat_valid)
);

// File: tb/burst_fill_cache_bench.sv
`timescale 1ns/1ps
module burst_fill_cache_bench;

  localparam int LW = 4;
  localparam int NL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_cmd_valid;
  logic [31:0] mem_cmd_addr;
  logic        mem_beat_valid = 1'b0;
  logic [31:0] mem_beat_data = '0;

  int checks = 0;
  int failures = 0;
  int stray_beats = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burst_fill_cache #(
    .ADDR_W(32), .DATA_W(32), .NUM_LINES(NL), .LINE_WORDS(LW)
  ) u_burst_fill_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_addr(mem_cmd_addr),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data)
  );

  function automatic logic [31:0] mdata(input logic [31:0] a);
    logic [29:0] w;
    w = a[31:2];
    return {w[15:0], w[29:14]} ^ 32'hA5C3_1E0F;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model: address cycle, four idle cycles, then one word per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (mem_cmd_valid) begin
        logic [31:0] base;
        base = mem_cmd_addr;
        mem_beat_valid = 1'b0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < LW; i++) begin
          mem_beat_valid = 1'b1;
          mem_beat_data  = mdata(base + 32'(4 * i));
          @(negedge clk);
        end
        mem_beat_valid = 1'b0;
        mem_beat_data  = '0;
      end else if (stray_beats > 0) begin
        mem_beat_valid = 1'b1;
        mem_beat_data  = 32'hDEAD_0000 | 32'(stray_beats);
        stray_beats--;
      end else begin
        mem_beat_valid = 1'b0;
      end
    end
  end

  // One read; checks latency, data, command count and address, stall
  task automatic do_read(input logic [31:0] a, input bit exp_hit, input string req);
    int lat;
    int cmds;
    int exp_lat;
    logic [31:0] caddr;
    logic [31:0] got;
    logic [31:0] exp_caddr;
    @(negedge clk);
    check(req_ready == 1'b1, req, "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    lat = 0; cmds = 0; caddr = '0; got = '0;
    for (int c = 1; c <= 40 && lat == 0; c++) begin
      @(negedge clk);
      if (c == 1) req_valid = 1'b0;
      if (mem_cmd_valid) begin cmds++; caddr = mem_cmd_addr; end
      if (c == 2 && !exp_hit)
        check(req_ready == 1'b0, "R4", "ready during refill", 32'(req_ready), 32'd0);
      if (rsp_valid) begin
        lat = c;
        got = rsp_data;
        if (!exp_hit)
          check(req_ready == 1'b1, "R4", "ready in response cycle", 32'(req_ready), 32'd1);
      end
    end
    exp_lat = exp_hit ? 1 : 6 + LW;
    check(lat == exp_lat, exp_hit ? "R2" : "R6", "response latency", 32'(lat), 32'(exp_lat));
    check(got == mdata(a), exp_hit ? "R2" : "R5", "response data", got, mdata(a));
    check(cmds == (exp_hit ? 0 : 1), "R3", "bus command count", 32'(cmds), exp_hit ? 32'd0 : 32'd1);
    if (!exp_hit) begin
      exp_caddr = a & ~32'(4 * LW - 1);
      check(caddr == exp_caddr, "R3", "aligned burst address", caddr, exp_caddr);
    end
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_cmd_valid == 1'b0, "R1", "reset cmd", 32'(mem_cmd_valid), 32'd0);
    do_read(32'h0000_0040, 1'b0, "R1");
  endtask

  task automatic t_fill_and_hits();
    do_read(32'h0000_0100, 1'b0, "R3");
    do_read(32'h0000_0100, 1'b1, "R2");
    do_read(32'h0000_0104, 1'b1, "R7");
    do_read(32'h0000_0108, 1'b1, "R5");
    do_read(32'h0000_010C, 1'b1, "R7");
  endtask

  task automatic t_byte_bits_r10();
    do_read(32'h0000_0105, 1'b1, "R10");
    do_read(32'h0000_010F, 1'b1, "R10");
  endtask

  task automatic t_mid_word_miss_r5();
    do_read(32'h1234_5678, 1'b0, "R5");
    do_read(32'h1234_5670, 1'b1, "R5");
    do_read(32'h1234_567C, 1'b1, "R5");
  endtask

  task automatic t_conflict_r8();
    do_read(32'h0000_0200, 1'b0, "R8");
    do_read(32'h0000_0104, 1'b0, "R8");
    do_read(32'h0000_0204, 1'b0, "R8");
  endtask

  task automatic t_last_index_r7();
    do_read(32'hABCD_EFFC, 1'b0, "R7");
    do_read(32'hABCD_EFF0, 1'b1, "R7");
  endtask

  task automatic t_stray_beats_r9();
    int seen;
    seen = 0;
    @(negedge clk);
    stray_beats = 3;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (rsp_valid) seen++;
    end
    check(seen == 0, "R9", "no response from stray beats", 32'(seen), 32'd0);
    check(req_ready == 1'b1, "R9", "ready after stray beats", 32'(req_ready), 32'd1);
    do_read(32'h0000_0200, 1'b1, "R9");
    do_read(32'h0000_020C, 1'b1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_hits();
    t_byte_bits_r10();
    t_mid_word_miss_r5();
    t_conflict_r8();
    t_last_index_r7();
    t_stray_beats_r9();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule